// File: doc/BRIEF.md
# Two-Wire Slave with Write-Protected Register and Lookup-Table Memory

This block is a serial slave on a two-wire (I2C-style) bus. It holds 80 bytes of flip-flop storage. Sixteen control and status bytes sit at 80h–8Fh and a 64-byte lookup table sits at 90h–CFh. SCL and SDA are oversampled by the system clock and passed through a synchronizer. The slave then finds START and STOP conditions, receives bytes most significant bit first and pulls SDA low (open drain) for acknowledge and read-data bits.

A transaction opens with a START and a slave address byte. The upper nibble must equal the device-type code and bits 3..1 must equal three strap pins. A write carries one word-address byte followed by data bytes. A read returns bytes from the current pointer. Combining a write of the word address, a repeated START and a read gives a random read. Storage is guarded at two levels. A write-enable latch must be set before any location other than the latch itself can change. Reserved and unmapped addresses never change, whatever the latch holds.

Top module: `twi_lut_slave`

## Requirements
- R1: A START seen at any point puts the slave into address reception. A STOP seen at any point returns it to idle with SDA released. A byte cut short by a START is never stored.
- R2: The slave pulls SDA low on the ninth clock of the address byte only when bits 7..4 are 1010 and bits 3..1 equal strap_i[2:0]. On any other address byte it stays silent for the rest of the transaction.
- R3: Bytes travel MSB first. The slave samples SDA on rising SCL and changes its own SDA drive only after falling SCL.
- R4: After a write-direction address, the next byte is taken as the word address, is acknowledged, and loads the address pointer.
- R5: Every data byte in a write is acknowledged. When the latch is set, it is stored at the pointer if that location is writable (80h, 81h, 83h, 85h, 86h, 90h–CFh).
- R6: The write-enable latch is bit 0 of location 87h. It can be written whatever its current state, and it reads back as 0000000b where b is the latch value.
- R7: While the latch is clear, a write to any location other than 87h leaves the stored value unchanged.
- R8: Locations 82h, 84h and 88h–8Fh never change and always read 00h.
- R9: Addresses below 80h or above CFh are acknowledged but never written, and they read 00h.
- R10: After each data byte, the pointer advances by one within its 16-byte page. Bits 3..0 wrap from Fh to 0h and bits 7..4 stay unchanged.
- R11: In a read, the slave drives each data bit and releases SDA on the acknowledge bit. It continues with the next byte on a master ACK and stops driving after a master NACK.
- R12: After reset, all storage and the latch are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| strap_i | input | 3 | Device address strap pins, matched to address bits 3..1 |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The data-byte commit and the pointer advance happen on the same falling SCL edge. Their interaction is tested by a three-byte burst that starts at 9Eh: the third byte must land at 90h and not at A0h. The result is judged by reading 9Eh, 9Fh and 90h back in one burst. The bench also sends a START half way through a data byte. It then checks that the byte that was cut short left the target register at 00h.

// File: rtl/twi_lut_pkg.sv
package twi_lut_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVA,
        ST_ACK_DEV,
        ST_WADDR,
        ST_ACK_WA,
        ST_WDATA,
        ST_ACK_WD,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } twi_state_e;

    typedef struct packed {
        twi_state_e  state;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic [7:0]  ptr;
        logic        rw;
        logic        oe;
        logic        nack;
    } twi_ctx_t;

    function automatic logic in_window(input logic [7:0] a, input int base, input int depth);
        return (int'(a) >= base) && (int'(a) < base + depth);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PW-1:0] scl;
        logic [PW-1:0] sda;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d.scl = {pipe_q.scl[PW-2:0], scl_i};
        pipe_d.sda = {pipe_q.sda[PW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = pipe_q.scl[PW-2];
    assign scl_prev = pipe_q.scl[PW-1];
    assign sda_now  = pipe_q.sda[PW-2];
    assign sda_prev = pipe_q.sda[PW-1];

    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/twi_regmap.sv
module twi_regmap
    import twi_lut_pkg::*;
#(
    parameter int              REG_BASE  = 'h80,
    parameter int              REG_DEPTH = 16,
    parameter int              LUT_BASE  = 'h90,
    parameter int              LUT_DEPTH = 64,
    parameter int              WEL_OFS   = 7,
    parameter logic [REG_DEPTH-1:0] RSV_MASK = 16'hFF14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data
);
    localparam int REG_AW = $clog2(REG_DEPTH);
    localparam int LUT_AW = $clog2(LUT_DEPTH);

    logic [7:0] reg_q [REG_DEPTH];
    logic [7:0] reg_d [REG_DEPTH];
    logic [7:0] lut_q [LUT_DEPTH];
    logic [7:0] lut_d [LUT_DEPTH];
    logic       wel_q, wel_d;
    logic [7:0] reg_rd [REG_DEPTH];

    logic [REG_AW-1:0] w_roff, r_roff;
    logic [LUT_AW-1:0] w_loff, r_loff;

    assign w_roff = REG_AW'(int'(wr_addr) - REG_BASE);
    assign r_roff = REG_AW'(int'(rd_addr) - REG_BASE);
    assign w_loff = LUT_AW'(int'(wr_addr) - LUT_BASE);
    assign r_loff = LUT_AW'(int'(rd_addr) - LUT_BASE);

    // next state: the latch location is always writable, the rest only with the latch set
    always_comb begin
        reg_d = reg_q;
        lut_d = lut_q;
        wel_d = wel_q;
        if (wr_stb) begin
            if (int'(wr_addr) == REG_BASE + WEL_OFS) begin
                wel_d = wr_data[0];
            end else if (wel_q) begin
                if (in_window(wr_addr, REG_BASE, REG_DEPTH)) begin
                    if (!RSV_MASK[w_roff]) reg_d[w_roff] = wr_data;
                end else if (in_window(wr_addr, LUT_BASE, LUT_DEPTH)) begin
                    lut_d[w_loff] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_DEPTH; i++) reg_q[i] <= '0;
            for (int i = 0; i < LUT_DEPTH; i++) lut_q[i] <= '0;
            wel_q <= 1'b0;
        end else begin
            reg_q <= reg_d;
            lut_q <= lut_d;
            wel_q <= wel_d;
        end
    end

    // read view per control byte: latch, reserved zero, or stored value
    for (genvar g = 0; g < REG_DEPTH; g++) begin : g_rview
        if (g == WEL_OFS) begin : g_wel
            assign reg_rd[g] = {7'b0, wel_q};
        end else if (RSV_MASK[g]) begin : g_rsv
            assign reg_rd[g] = 8'h00;
        end else begin : g_mem
            assign reg_rd[g] = reg_q[g];
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (in_window(rd_addr, REG_BASE, REG_DEPTH))      rd_data = reg_rd[r_roff];
        else if (in_window(rd_addr, LUT_BASE, LUT_DEPTH)) rd_data = lut_q[r_loff];
    end
endmodule

// File: rtl/twi_lut_slave.sv
module twi_lut_slave
    import twi_lut_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b1010,
    parameter int         SYNC_STAGES = 2,
    parameter int         PAGE_BYTES  = 16,
    parameter int         REG_BASE    = 'h80,
    parameter int         REG_DEPTH   = 16,
    parameter int         LUT_BASE    = 'h90,
    parameter int         LUT_DEPTH   = 64,
    parameter int         WEL_OFS     = 7,
    parameter logic [REG_DEPTH-1:0] RSV_MASK = 16'hFF14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);
    localparam int PB = $clog2(PAGE_BYTES);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic mem_wr;
    logic [7:0] rd_data;
    twi_ctx_t ctx_d, ctx_q;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_regmap #(
        .REG_BASE  (REG_BASE),
        .REG_DEPTH (REG_DEPTH),
        .LUT_BASE  (LUT_BASE),
        .LUT_DEPTH (LUT_DEPTH),
        .WEL_OFS   (WEL_OFS),
        .RSV_MASK  (RSV_MASK)
    ) i_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (mem_wr),
        .wr_addr (ctx_q.ptr),
        .wr_data (ctx_q.sh),
        .rd_addr (ctx_q.ptr),
        .rd_data (rd_data)
    );

    function automatic logic [7:0] page_step(input logic [7:0] p);
        logic [7:0] r;
        r = p;
        r[PB-1:0] = p[PB-1:0] + 1'b1;
        return r;
    endfunction

    always_comb begin
        ctx_d  = ctx_q;
        mem_wr = 1'b0;
        if (start_det) begin
            ctx_d.state = ST_DEVA;
            ctx_d.cnt   = '0;
            ctx_d.oe    = 1'b0;
        end else if (stop_det) begin
            ctx_d.state = ST_IDLE;
            ctx_d.cnt   = '0;
            ctx_d.oe    = 1'b0;
        end else if (scl_rise) begin
            case (ctx_q.state)
                ST_DEVA, ST_WADDR, ST_WDATA: begin
                    if (ctx_q.cnt < 4'd8) begin
                        ctx_d.sh  = {ctx_q.sh[6:0], sda_s};
                        ctx_d.cnt = ctx_q.cnt + 4'd1;
                    end
                end
                ST_RDATA: begin
                    if (ctx_q.cnt < 4'd8) ctx_d.cnt = ctx_q.cnt + 4'd1;
                end
                ST_RACK: ctx_d.nack = sda_s;
                default: ;
            endcase
        end else if (scl_fall) begin
            case (ctx_q.state)
                ST_DEVA: begin
                    if (ctx_q.cnt == 4'd8) begin
                        if (ctx_q.sh[7:4] == DEV_TYPE && ctx_q.sh[3:1] == strap_i) begin
                            ctx_d.state = ST_ACK_DEV;
                            ctx_d.oe    = 1'b1;
                            ctx_d.rw    = ctx_q.sh[0];
                        end else begin
                            ctx_d.state = ST_SKIP;
                        end
                    end
                end
                ST_ACK_DEV: begin
                    ctx_d.cnt = '0;
                    if (ctx_q.rw) begin
                        ctx_d.state = ST_RDATA;
                        ctx_d.sh    = rd_data;
                        ctx_d.oe    = ~rd_data[7];
                    end else begin
                        ctx_d.state = ST_WADDR;
                        ctx_d.oe    = 1'b0;
                    end
                end
                ST_WADDR: begin
                    if (ctx_q.cnt == 4'd8) begin
                        ctx_d.ptr   = ctx_q.sh;
                        ctx_d.oe    = 1'b1;
                        ctx_d.state = ST_ACK_WA;
                    end
                end
                ST_WDATA: begin
                    if (ctx_q.cnt == 4'd8) begin
                        mem_wr      = 1'b1;
                        ctx_d.ptr   = page_step(ctx_q.ptr);
                        ctx_d.oe    = 1'b1;
                        ctx_d.state = ST_ACK_WD;
                    end
                end
                ST_ACK_WA, ST_ACK_WD: begin
                    ctx_d.oe    = 1'b0;
                    ctx_d.cnt   = '0;
                    ctx_d.state = ST_WDATA;
                end
                ST_RDATA: begin
                    if (ctx_q.cnt == 4'd8) begin
                        ctx_d.oe    = 1'b0;
                        ctx_d.ptr   = page_step(ctx_q.ptr);
                        ctx_d.state = ST_RACK;
                    end else begin
                        ctx_d.sh = {ctx_q.sh[6:0], 1'b0};
                        ctx_d.oe = ~ctx_q.sh[6];
                    end
                end
                ST_RACK: begin
                    ctx_d.cnt = '0;
                    if (ctx_q.nack) begin
                        ctx_d.state = ST_SKIP;
                    end else begin
                        ctx_d.state = ST_RDATA;
                        ctx_d.sh    = rd_data;
                        ctx_d.oe    = ~rd_data[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign sda_oe_o = ctx_q.oe;
endmodule

// File: rtl/twi_lut_slave_chk.sv
module twi_lut_slave_chk
    import twi_lut_pkg::*;
#(
    parameter int PB      = 4,
    parameter int MAP_LO  = 'h80,
    parameter int MAP_HI  = 'hCF
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_det,
    input logic       stop_det,
    input twi_state_e state,
    input logic       sda_oe,
    input logic [7:0] sh,
    input logic [2:0] strap,
    input logic       mem_wr,
    input logic [7:0] ptr,
    input logic [7:0] rd_data
);
    assert_start_rearm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_DEVA);

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe);

    assert_ack_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ACK_DEV |-> (sh[7:4] == 4'b1010 && sh[3:1] == strap));

    assert_page_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (ptr[7:PB] == $past(ptr[7:PB]) &&
                    ptr[PB-1:0] == $past(ptr[PB-1:0]) + 1'b1));

    assert_rack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RACK |-> !sda_oe);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ptr) < MAP_LO || int'(ptr) > MAP_HI) |-> rd_data == 8'h00);
endmodule

bind twi_lut_slave twi_lut_slave_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (ctx_q.state),
    .sda_oe    (sda_oe_o),
    .sh        (ctx_q.sh),
    .strap     (strap_i),
    .mem_wr    (mem_wr),
    .ptr       (ctx_q.ptr),
    .rd_data   (rd_data)
);

// File: tb/test_twi_lut_slave.sv
module test_twi_lut_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;   // 250 MHz

    twi_lut_slave i_twi_lut_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    localparam int HALF = 20;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] got_q[$];
    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(4);
        scl = 1'b1;   wclk(HALF);
        sda_m = 1'b0; wclk(HALF);
        scl = 1'b0;   wclk(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(HALF);
        scl = 1'b1;   wclk(HALF);
        sda_m = 1'b1; wclk(HALF);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;  wclk(HALF);
        scl = 1'b1; wclk(HALF);
        scl = 1'b0; wclk(4);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wclk(HALF);
        scl = 1'b1;   wclk(HALF / 2);
        acked = ~sda_line;
        wclk(HALF / 2);
        scl = 1'b0;   wclk(4);
    endtask

    task automatic get_byte(input logic master_ack);
        logic [7:0] v;
        v = '0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wclk(HALF);
            scl = 1'b1;   wclk(HALF / 2);
            v[i] = sda_line;
            wclk(HALF / 2);
            scl = 1'b0;   wclk(4);
        end
        got_q.push_back(v);
        put_bit(~master_ack);
        sda_m = 1'b1;
    endtask

    task automatic send_acked(input logic [7:0] b, input string tag);
        logic a;
        put_byte(b, a);
        chk(a == 1'b1, tag, {7'b0, a}, 8'h01);
    endtask

    task automatic wr_tx(input logic [7:0] wa, input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input int n, input string tag);
        bus_start();
        send_acked({4'b1010, strap, 1'b0}, {tag, " R2 addr ack"});
        send_acked(wa, {tag, " R4 word ack"});
        if (n > 0) send_acked(d0, {tag, " R5 data ack"});
        if (n > 1) send_acked(d1, {tag, " R5 data ack"});
        if (n > 2) send_acked(d2, {tag, " R5 data ack"});
        bus_stop();
    endtask

    task automatic rd_tx(input logic [7:0] wa, input int n, input logic [7:0] e0,
                         input logic [7:0] e1, input logic [7:0] e2, input string tag);
        if (n > 0) exp_q.push_back('{e0, tag});
        if (n > 1) exp_q.push_back('{e1, tag});
        if (n > 2) exp_q.push_back('{e2, tag});
        bus_start();
        send_acked({4'b1010, strap, 1'b0}, {tag, " R2 addr ack"});
        send_acked(wa, {tag, " R4 word ack"});
        bus_start();
        send_acked({4'b1010, strap, 1'b1}, {tag, " R2 read addr ack"});
        for (int i = 0; i < n; i++) get_byte(i < n - 1);
        wclk(8);
        chk(sda_oe == 1'b0, {tag, " R11 released after nack"}, {7'b0, sda_oe}, 8'h00);
        bus_stop();
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g;
                exp_t       e;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk(1'b0, "scoreboard unexpected byte", g, 8'h00);
                end else begin
                    e = exp_q.pop_front();
                    chk(g === e.v, e.tag, g, e.v);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic a;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        chk(sda_oe == 1'b0, "R12 SDA released after reset", {7'b0, sda_oe}, 8'h00);

        // R2: strap mismatch and wrong device type
        bus_start();
        put_byte({4'b1010, 3'b000, 1'b0}, a);
        chk(a == 1'b0, "R2 strap mismatch nack", {7'b0, a}, 8'h00);
        put_byte(8'h90, a);
        chk(a == 1'b0, "R2 silent after mismatch", {7'b0, a}, 8'h00);
        bus_stop();
        bus_start();
        put_byte({4'b1011, strap, 1'b0}, a);
        chk(a == 1'b0, "R2 wrong type nack", {7'b0, a}, 8'h00);
        bus_stop();

        // R12: reset contents
        rd_tx(8'h90, 1, 8'h00, 8'h00, 8'h00, "R12 LUT 90h zero");
        rd_tx(8'hCF, 1, 8'h00, 8'h00, 8'h00, "R12 LUT CFh zero");

        // R7: latch clear blocks LUT write
        wr_tx(8'h90, 8'hA5, 8'h00, 8'h00, 1, "R7 locked write");
        rd_tx(8'h90, 1, 8'h00, 8'h00, 8'h00, "R7 locked write no effect");

        // R6: latch set, upper bits read zero
        wr_tx(8'h87, 8'hFF, 8'h00, 8'h00, 1, "R6 set latch");
        rd_tx(8'h87, 1, 8'h01, 8'h00, 8'h00, "R6 latch readback");

        // R5/R10/R11: burst write and burst read
        wr_tx(8'h90, 8'h11, 8'h22, 8'h33, 3, "R5 burst");
        rd_tx(8'h90, 3, 8'h11, 8'h22, 8'h33, "R11 burst read");

        // R10: page wrap on write and read
        wr_tx(8'h9E, 8'hAA, 8'hBB, 8'hCC, 3, "R10 wrap write");
        rd_tx(8'h9E, 3, 8'hAA, 8'hBB, 8'hCC, "R10 wrap read");

        // R8: reserved registers
        wr_tx(8'h82, 8'h5A, 8'h00, 8'h00, 1, "R8 rsv 82h");
        wr_tx(8'h84, 8'h5A, 8'h00, 8'h00, 1, "R8 rsv 84h");
        wr_tx(8'h8C, 8'h5A, 8'h00, 8'h00, 1, "R8 rsv 8Ch");
        rd_tx(8'h82, 1, 8'h00, 8'h00, 8'h00, "R8 82h reads zero");
        rd_tx(8'h84, 1, 8'h00, 8'h00, 8'h00, "R8 84h reads zero");
        rd_tx(8'h8C, 1, 8'h00, 8'h00, 8'h00, "R8 8Ch reads zero");

        // R3: bit order
        wr_tx(8'h86, 8'h80, 8'h00, 8'h00, 1, "R3 msb");
        wr_tx(8'h83, 8'h01, 8'h00, 8'h00, 1, "R3 lsb");
        rd_tx(8'h86, 1, 8'h80, 8'h00, 8'h00, "R3 86h msb first");
        rd_tx(8'h83, 1, 8'h01, 8'h00, 8'h00, "R3 83h lsb last");

        // R9: unmapped addresses
        wr_tx(8'hD0, 8'h77, 8'h00, 8'h00, 1, "R9 write D0h");
        wr_tx(8'h10, 8'h77, 8'h00, 8'h00, 1, "R9 write 10h");
        rd_tx(8'hD0, 1, 8'h00, 8'h00, 8'h00, "R9 D0h reads zero");
        rd_tx(8'h10, 1, 8'h00, 8'h00, 8'h00, "R9 10h reads zero");
        rd_tx(8'h90, 1, 8'hCC, 8'h00, 8'h00, "R9 no alias into 90h");

        // R1: START inside a data byte
        bus_start();
        send_acked({4'b1010, strap, 1'b0}, "R1 addr ack");
        send_acked(8'h85, "R1 word ack");
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        bus_stop();
        rd_tx(8'h85, 1, 8'h00, 8'h00, 8'h00, "R1 cut byte not stored");

        // R7: clear latch then try again
        wr_tx(8'h87, 8'h00, 8'h00, 8'h00, 1, "R6 clear latch");
        wr_tx(8'h91, 8'h99, 8'h00, 8'h00, 1, "R7 relocked write");
        rd_tx(8'h91, 1, 8'h22, 8'h00, 8'h00, "R7 91h unchanged");
        rd_tx(8'h87, 1, 8'h00, 8'h00, 8'h00, "R6 latch cleared");

        wclk(20);
        chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule